// File: doc/BRIEF.md
# Auto-Reload Countdown Timer with Interrupt

This block is the periodic-interrupt timer of a real-time-clock style design. Software writes an 8-bit start value and a small control word. The block then counts that value down, one step per tick of a selectable source clock. When the count runs out it raises a timer flag, reloads the start value and keeps counting. The flag stays set until the flags register is read. An interrupt line follows the flag in level mode. In pulse mode it gives a short pulse whose width depends on the selected source.

All source ticks come from a single 8192 Hz clock-enable strobe through a free-running internal prescaler. A minute counter on top of the one-second tick gives the slowest source. Clearing the enable bit freezes the count where it stands. Setting the enable bit again resumes from that value. A start value of zero keeps the timer silent.

Top module: `rtc_countdown_timer`

## Requirements
- R1: The source select field picks the countdown step rate: code 0 steps once every 2 base strobes (4096 Hz), code 1 once every 128 strobes (64 Hz), code 2 once every 8192 strobes (1 Hz), and code 3 once every 60 one-second ticks (1/60 Hz). With start value n, consecutive expiries are n steps apart.
- R2: On expiry the counter reloads the start value in the same edge and keeps counting, whether or not the flag is still set and in either interrupt mode.
- R3: Expiry sets the timer flag at that clock edge. A flags read clears the flag at the next edge. When a read and an expiry fall in the same cycle, the flag stays set.
- R4: In level mode (mode bit 0) the interrupt output is high exactly while the flag is set and interrupt enable is 1. It drops once the flag is cleared by a read.
- R5: In pulse mode (mode bit 1) the interrupt rises at the same edge as the flag. It stays high for 1 base strobe with source 0, 64 strobes with source 1, and 128 strobes with sources 2 and 3.
- R6: While the enable bit is 0 the count does not change and no expiry occurs. After enable returns to 1, counting continues from the held value.
- R7: Reset clears the enable bit, interrupt enable, mode bit, flag, start value and count. It sets the source select to 3.
- R8: A start value of 0 stops the timer: no expiry and no flag, however long the timer is enabled.
- R9: A write of the timer value loads both the start value and the live count at that edge, so the count output shows the new value in the following cycle.
- R10: With interrupt enable 0 the interrupt output stays low in both modes. The flag still follows R3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset (also the power-down event) |
| tick_8k_i | input | 1 | One-cycle 8192 Hz clock-enable strobe |
| val_wr_i | input | 1 | Timer value write strobe |
| val_data_i | input | VAL_W | Timer value write data |
| ctrl_wr_i | input | 1 | Control word write strobe |
| ctrl_en_i | input | 1 | Timer enable bit |
| ctrl_ie_i | input | 1 | Interrupt enable bit |
| ctrl_pulse_i | input | 1 | Interrupt mode: 0 level, 1 pulse |
| ctrl_src_i | input | 2 | Source clock select code |
| flags_rd_i | input | 1 | Flags register read strobe (clears the flag) |
| tf_o | output | 1 | Timer flag |
| irq_o | output | 1 | Interrupt output, active high |
| count_o | output | VAL_W | Live countdown value |

## Verification
The embedded properties watch every cycle for several rules. Each expiry must set the flag and reload the start value. A read without a coincident expiry must clear the flag. A value write must load both registers. A disabled timer must hold its count. A zero start value must keep the count at zero. The pulse counter must stay within its longest width, and the slower ticks must nest inside the faster ones. Only the directed scenarios can show the rest. These are the actual expiry spacing for each source code, and the measured pulse widths with their alignment to the flag. They also cover interrupt gating by the enable bits in level mode, resumption after a pause, and the disabled state after reset.

// File: rtl/rtc_tmr_pkg.sv
package rtc_tmr_pkg;

    typedef enum logic [1:0] {
        SRC_FAST = 2'b00,
        SRC_MID  = 2'b01,
        SRC_SEC  = 2'b10,
        SRC_MIN  = 2'b11
    } src_sel_e;

    typedef struct packed {
        logic     en;
        logic     ie;
        logic     pulse;
        src_sel_e src;
    } tmr_ctrl_t;

    localparam tmr_ctrl_t CTRL_RESET = '{en: 1'b0, ie: 1'b0, pulse: 1'b0, src: SRC_MIN};

endpackage

// File: rtl/rtc_tmr_prescaler.sv
module rtc_tmr_prescaler #(
    parameter int LOG_FAST = 1,
    parameter int LOG_MID  = 7,
    parameter int LOG_SEC  = 13,
    parameter int MIN_DIV  = 60
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       stb_i,
    output logic [3:0] ticks_o
);
    localparam int MIN_W = (MIN_DIV > 1) ? $clog2(MIN_DIV) : 1;
    localparam logic [MIN_W-1:0] MIN_LAST = MIN_W'(MIN_DIV - 1);

    typedef struct packed {
        logic [LOG_SEC-1:0] pre;
        logic [MIN_W-1:0]   mins;
    } pre_state_t;

    pre_state_t st_q, st_d;
    logic tick_fast, tick_mid, tick_sec, tick_min;

    always_comb begin
        tick_fast = stb_i && (&st_q.pre[LOG_FAST-1:0]);
        tick_mid  = stb_i && (&st_q.pre[LOG_MID-1:0]);
        tick_sec  = stb_i && (&st_q.pre);
        tick_min  = tick_sec && (st_q.mins == MIN_LAST);

        st_d = st_q;
        if (stb_i) begin
            st_d.pre = st_q.pre + 1'b1;
        end
        if (tick_sec) begin
            st_d.mins = (st_q.mins == MIN_LAST) ? '0 : st_q.mins + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ticks_o = {tick_min, tick_sec, tick_mid, tick_fast};

    a_r1_min_inside_sec: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_o[3] |-> ticks_o[2]);
    a_r1_sec_inside_mid: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ticks_o[2] |-> (ticks_o[1] && ticks_o[0]));
    a_r1_min_count_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.mins <= MIN_LAST);

endmodule

// File: rtl/rtc_tmr_counter.sv
module rtc_tmr_counter #(
    parameter int VAL_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             step_i,
    input  logic             en_i,
    input  logic             wr_i,
    input  logic [VAL_W-1:0] wr_data_i,
    output logic [VAL_W-1:0] count_o,
    output logic             expire_o
);
    localparam logic [VAL_W-1:0] ONE = VAL_W'(1);

    typedef struct packed {
        logic [VAL_W-1:0] reload;
        logic [VAL_W-1:0] count;
    } cnt_state_t;

    cnt_state_t st_q, st_d;
    logic       stepping;

    always_comb begin
        st_d     = st_q;
        stepping = !wr_i && step_i && en_i && (st_q.reload != '0);
        expire_o = stepping && (st_q.count <= ONE);
        if (wr_i) begin
            st_d.reload = wr_data_i;
            st_d.count  = wr_data_i;
        end else if (expire_o) begin
            st_d.count = st_q.reload;
        end else if (stepping) begin
            st_d.count = st_q.count - ONE;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign count_o = st_q.count;

    a_r2_reload_on_expiry: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_o |=> (st_q.count == $past(st_q.reload)));
    a_r6_hold_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!en_i && !wr_i) |=> $stable(st_q.count));
    a_r6_no_expiry_when_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !en_i |-> !expire_o);
    a_r8_zero_stays: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (st_q.reload == '0 && st_q.count == '0 && !wr_i) |=> (st_q.count == '0));
    a_r9_write_loads: assert property (@(posedge clk_i) disable iff (!rst_ni)
        wr_i |=> (st_q.count == $past(wr_data_i) && st_q.reload == $past(wr_data_i)));

endmodule

// File: rtl/rtc_tmr_irq.sv
module rtc_tmr_irq #(
    parameter int PW_FAST = 1,
    parameter int PW_MID  = 64,
    parameter int PW_SLOW = 128
) (
    input  logic                  clk_i,
    input  logic                  rst_ni,
    input  logic                  stb_i,
    input  logic                  expire_i,
    input  logic                  rd_i,
    input  logic                  ie_i,
    input  logic                  pulse_i,
    input  rtc_tmr_pkg::src_sel_e src_i,
    output logic                  tf_o,
    output logic                  irq_o
);
    import rtc_tmr_pkg::*;

    localparam int PW_W = $clog2(PW_SLOW + 1);
    localparam logic [PW_W-1:0] PW_MAX = PW_W'(PW_SLOW);

    typedef struct packed {
        logic            tf;
        logic [PW_W-1:0] pw;
    } irq_state_t;

    irq_state_t      st_q, st_d;
    logic [PW_W-1:0] pw_len;

    always_comb begin
        case (src_i)
            SRC_FAST: pw_len = PW_W'(PW_FAST);
            SRC_MID:  pw_len = PW_W'(PW_MID);
            default:  pw_len = PW_W'(PW_SLOW);
        endcase

        st_d = st_q;
        if (expire_i) begin
            st_d.tf = 1'b1;
        end else if (rd_i) begin
            st_d.tf = 1'b0;
        end

        if (expire_i) begin
            st_d.pw = pw_len;
        end else if (stb_i && st_q.pw != '0) begin
            st_d.pw = st_q.pw - 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tf_o  = st_q.tf;
    assign irq_o = ie_i && (pulse_i ? (st_q.pw != '0) : st_q.tf);

    a_r3_flag_set: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> tf_o);
    a_r3_flag_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (rd_i && !expire_i) |=> !tf_o);
    a_r5_pulse_bound: assert property (@(posedge clk_i) disable iff (!rst_ni)
        st_q.pw <= PW_MAX);
    a_r5_pulse_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
        expire_i |=> (st_q.pw != '0));

endmodule

// File: rtl/rtc_countdown_timer.sv
module rtc_countdown_timer #(
    parameter int VAL_W    = 8,
    parameter int LOG_FAST = 1,
    parameter int LOG_MID  = 7,
    parameter int LOG_SEC  = 13,
    parameter int MIN_DIV  = 60,
    parameter int PW_FAST  = 1,
    parameter int PW_MID   = 64,
    parameter int PW_SLOW  = 128
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             tick_8k_i,
    input  logic             val_wr_i,
    input  logic [VAL_W-1:0] val_data_i,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_en_i,
    input  logic             ctrl_ie_i,
    input  logic             ctrl_pulse_i,
    input  logic [1:0]       ctrl_src_i,
    input  logic             flags_rd_i,
    output logic             tf_o,
    output logic             irq_o,
    output logic [VAL_W-1:0] count_o
);
    import rtc_tmr_pkg::*;

    tmr_ctrl_t  ctrl_q, ctrl_d;
    logic [3:0] ticks;
    logic       step;
    logic       expire;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_wr_i) begin
            ctrl_d.en    = ctrl_en_i;
            ctrl_d.ie    = ctrl_ie_i;
            ctrl_d.pulse = ctrl_pulse_i;
            ctrl_d.src   = src_sel_e'(ctrl_src_i);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            ctrl_q <= CTRL_RESET;
        end else begin
            ctrl_q <= ctrl_d;
        end
    end

    rtc_tmr_prescaler #(
        .LOG_FAST (LOG_FAST),
        .LOG_MID  (LOG_MID),
        .LOG_SEC  (LOG_SEC),
        .MIN_DIV  (MIN_DIV)
    ) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .stb_i   (tick_8k_i),
        .ticks_o (ticks)
    );

    assign step = ticks[ctrl_q.src];

    rtc_tmr_counter #(
        .VAL_W (VAL_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .step_i    (step),
        .en_i      (ctrl_q.en),
        .wr_i      (val_wr_i),
        .wr_data_i (val_data_i),
        .count_o   (count_o),
        .expire_o  (expire)
    );

    rtc_tmr_irq #(
        .PW_FAST (PW_FAST),
        .PW_MID  (PW_MID),
        .PW_SLOW (PW_SLOW)
    ) u_irq (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .stb_i    (tick_8k_i),
        .expire_i (expire),
        .rd_i     (flags_rd_i),
        .ie_i     (ctrl_q.ie),
        .pulse_i  (ctrl_q.pulse),
        .src_i    (ctrl_q.src),
        .tf_o     (tf_o),
        .irq_o    (irq_o)
    );

    a_r10_irq_needs_ie: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> ctrl_q.ie);
    a_r4_level_follows_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (irq_o && !ctrl_q.pulse) |-> tf_o);

endmodule

// File: tb/rtc_countdown_timer_tb.sv
`timescale 1ns/1ps
module rtc_countdown_timer_tb_top;

    localparam int VAL_W   = 8;
    localparam int LOG_SEC = 9;
    localparam int MIN_DIV = 3;
    localparam int P_FAST  = 2;
    localparam int P_MID   = 128;
    localparam int P_SEC   = 1 << LOG_SEC;
    localparam int P_MIN   = P_SEC * MIN_DIV;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             stb = 1'b1;
    logic             val_wr = 1'b0;
    logic [VAL_W-1:0] val_data = '0;
    logic             ctrl_wr = 1'b0;
    logic             c_en = 1'b0, c_ie = 1'b0, c_pulse = 1'b0;
    logic [1:0]       c_src = 2'b00;
    logic             rd = 1'b0;
    logic             tf, irq;
    logic [VAL_W-1:0] cnt;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    rtc_countdown_timer #(
        .VAL_W   (VAL_W),
        .LOG_SEC (LOG_SEC),
        .MIN_DIV (MIN_DIV)
    ) dut_i (
        .clk_i        (clk),
        .rst_ni       (rst_n),
        .tick_8k_i    (stb),
        .val_wr_i     (val_wr),
        .val_data_i   (val_data),
        .ctrl_wr_i    (ctrl_wr),
        .ctrl_en_i    (c_en),
        .ctrl_ie_i    (c_ie),
        .ctrl_pulse_i (c_pulse),
        .ctrl_src_i   (c_src),
        .flags_rd_i   (rd),
        .tf_o         (tf),
        .irq_o        (irq),
        .count_o      (cnt)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp_v);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp_v);
        end
    endtask

    task automatic write_ctrl(input logic en, input logic ie, input logic pulse, input logic [1:0] src);
        @(negedge clk);
        c_en = en; c_ie = ie; c_pulse = pulse; c_src = src; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
    endtask

    task automatic write_value(input logic [VAL_W-1:0] v);
        @(negedge clk);
        val_data = v; val_wr = 1'b1;
        @(negedge clk);
        val_wr = 1'b0;
    endtask

    task automatic read_flags();
        rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
    endtask

    task automatic wait_tf_rise();
        while (tf) @(negedge clk);
        while (!tf) @(negedge clk);
    endtask

    task automatic t_reset();
        check(tf == 1'b0, "R7 tf after reset", tf, 0);
        check(irq == 1'b0, "R7 irq after reset", irq, 0);
        check(cnt == '0, "R7 count after reset", cnt, 0);
        write_value(8'd5);
        check(cnt == 8'd5, "R9 count loaded by write", cnt, 5);
        repeat (300) @(negedge clk);
        check(cnt == 8'd5 && !tf, "R7 enable cleared by reset, count held", cnt, 5);
    endtask

    task automatic t_period(input logic [1:0] src, input int n, input int step, input string req);
        int c;
        write_ctrl(1'b1, 1'b1, 1'b0, src);
        write_value(VAL_W'(n));
        @(negedge clk);
        read_flags();
        wait_tf_rise();
        check(cnt == VAL_W'(n), "R2 reloaded while flag set", cnt, n);
        read_flags();
        check(!tf, "R3 read clears flag", tf, 0);
        c = 1;
        while (!tf) begin
            @(negedge clk);
            c++;
        end
        check(c == n * step, req, c, n * step);
    endtask

    task automatic t_level();
        write_ctrl(1'b1, 1'b1, 1'b0, 2'b01);
        write_value(8'd2);
        read_flags();
        wait_tf_rise();
        check(irq == 1'b1, "R4 level irq with flag", irq, 1);
        write_ctrl(1'b1, 1'b0, 1'b0, 2'b01);
        check(irq == 1'b0 && tf == 1'b1, "R10 ie=0 masks level irq", irq, 0);
        write_ctrl(1'b1, 1'b1, 1'b0, 2'b01);
        check(irq == 1'b1, "R4 irq back with ie", irq, 1);
        read_flags();
        check(irq == 1'b0, "R4 irq drops after read", irq, 0);
    endtask

    task automatic t_priority();
        int ones = 0;
        write_ctrl(1'b1, 1'b0, 1'b0, 2'b00);
        write_value(8'd1);
        @(negedge clk);
        rd = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (tf) ones++;
        end
        rd = 1'b0;
        check(ones == 5, "R3 expiry wins over read", ones, 5);
    endtask

    task automatic t_pulse(input logic [1:0] src, input int width, input logic ie, input string req);
        int w = 0;
        int hi = 0;
        write_ctrl(1'b1, ie, 1'b1, src);
        write_value(8'd2);
        read_flags();
        wait_tf_rise();
        if (ie) begin
            check(irq == 1'b1, "R5 irq rises with flag", irq, 1);
            while (irq) begin
                w++;
                @(negedge clk);
            end
            check(w == width, req, w, width);
        end else begin
            for (int i = 0; i < 8; i++) begin
                if (irq) hi++;
                @(negedge clk);
            end
            check(hi == 0, req, hi, 0);
        end
    endtask

    task automatic t_pause();
        logic [VAL_W-1:0] held;
        write_ctrl(1'b1, 1'b0, 1'b0, 2'b01);
        write_value(8'd200);
        repeat (300) @(negedge clk);
        read_flags();
        write_ctrl(1'b0, 1'b0, 1'b0, 2'b01);
        held = cnt;
        repeat (1000) @(negedge clk);
        check(cnt == held, "R6 count held while disabled", cnt, held);
        check(!tf, "R6 no expiry while disabled", tf, 0);
        @(negedge clk);
        c_en = 1'b1; c_ie = 1'b0; c_pulse = 1'b0; c_src = 2'b01; ctrl_wr = 1'b1;
        @(negedge clk);
        ctrl_wr = 1'b0;
        repeat (127) @(negedge clk);
        check(cnt == held - 1'b1, "R6 resumes from held value", cnt, held - 1);
    endtask

    task automatic t_zero();
        write_ctrl(1'b1, 1'b1, 1'b0, 2'b00);
        write_value(8'd0);
        read_flags();
        repeat (200) @(negedge clk);
        check(!tf && !irq && cnt == '0, "R8 zero value stops timer", tf, 0);
    endtask

    initial begin
        #(4 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_period(2'b00, 3, P_FAST, "R1 period source 0");
        t_period(2'b01, 2, P_MID, "R1 period source 1");
        t_period(2'b10, 2, P_SEC, "R1 period source 2");
        t_period(2'b11, 1, P_MIN, "R1 period source 3");
        t_level();
        t_priority();
        t_pulse(2'b00, 1, 1'b1, "R5 pulse width source 0");
        t_pulse(2'b01, 64, 1'b1, "R5 pulse width source 1");
        t_pulse(2'b10, 128, 1'b1, "R5 pulse width source 2");
        t_pulse(2'b11, 128, 1'b1, "R5 pulse width source 3");
        t_pulse(2'b01, 0, 1'b0, "R10 ie=0 masks pulse irq");
        t_pause();
        t_zero();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule